// File: doc/BRIEF.md
# Indexed Addressing Bus-Cycle Sequencer

This block produces the bus cycles that an 8-bit processor issues once the operands of an indexed memory instruction are known. That covers absolute indexed by either index register and indirect indexed by Y. The inputs are a 16-bit base, an 8-bit index, an access class and the program counter. From these the block emits, one cycle at a time, the address, the read/write strobe and a code for the kind of cycle. A done flag marks the last bus cycle of the sequence.

The interesting cycle is the extra indexing cycle. When the low-byte sum of base and index carries, the high byte is not yet correct. In that cycle the only address on hand is the final address less 0x100. Stores and read-modify-writes always take the extra cycle, carry or not. The parameter `PC_ON_CARRY` picks what the extra cycle shows:
- At 0, the bus shows the partially formed address.
- At 1, a carry puts the program counter on the bus instead.
- At 1 with no carry, the extra cycle still reads the complete final address. This gives the spurious read that precedes a store.

Top module: `idx_bus_seq`

## Requirements
- R1: The final access address equals base plus the zero-extended index, taken modulo 0x10000 (0xFFxx plus a carrying index wraps to 0x00xx).
- R2: A load (access code 0) whose low-byte sum does not carry produces exactly one bus cycle: a read (kind 2, strobe high) at the final address.
- R3: A load whose low-byte sum carries produces an extra cycle (kind 1) followed by a read (kind 2) at the final address.
- R4: With `PC_ON_CARRY`=0, every extra cycle is a read at {base high byte, low byte of the sum}. With a carry this equals the final address minus 0x100.
- R5: With `PC_ON_CARRY`=1, an extra cycle caused by a carry reads at the program counter, for every access class.
- R6: A store (access code 1) always produces an extra read cycle followed by one write cycle (kind 4, strobe low) at the final address. The strobe is low in no other cycle.
- R7: With `PC_ON_CARRY`=1, a store without carry reads the final address in its extra cycle, which is the same address written in the next cycle.
- R8: A read-modify-write (access code 2) produces an extra read, then a read (kind 2), a dummy cycle (kind 3, strobe high) and a write (kind 4), the last three at the final address. Without a carry, the extra cycle also uses the final address.
- R9: A start pulse is accepted only while idle. Start pulses and input changes during a sequence do not alter its trace.
- R10: While idle the block shows kind 0, address 0 and strobe high. `seq_done` is high exactly during the last bus cycle, and the first bus cycle appears in the cycle after the accepting clock edge.
- R11: Access code 3 behaves as a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence with the presented operands |
| base_addr | input | 16 | Base address |
| index_val | input | 8 | Index value |
| access | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 load |
| prog_ctr | input | 16 | Program counter (last instruction byte) |
| bus_addr | output | 16 | Address for this cycle |
| bus_rnw | output | 1 | 1 read, 0 write |
| cyc_kind | output | 3 | 0 idle, 1 extra, 2 read, 3 dummy, 4 write |
| seq_done | output | 1 | High during the final bus cycle |
| seq_busy | output | 1 | High while a sequence runs |

## Verification
The hardest case to reach is the wrap of the high-byte increment when a carry occurs with base high byte 0xFF. It must be tested under both policies and all access classes, because the partially formed address and the final address then lie in different halves of the map. The sweep crosses base low bytes 0x00, 0x7F, 0x80 and 0xFF with high bytes 0x00, 0x12 and 0xFF, and with indexes 0x00, 0x01, 0x80 and 0xFF. This lands on both sides of the carry boundary and on the wrap. Two instances, one per policy, receive the same stimulus. For R9, a subset of sequences pulses start again with inverted operands after the first bus cycle.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int IDX_W  = 8;
    localparam int HI_W   = ADDR_W - IDX_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        CY_IDLE  = 3'd0,
        CY_EXTRA = 3'd1,
        CY_READ  = 3'd2,
        CY_DUMMY = 3'd3,
        CY_WRITE = 3'd4
    } cyc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        acc_e              acc;
        logic [ADDR_W-1:0] pc;
    } op_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pfa;
        logic              carry;
    } addr_t;

    // reserved access code folds onto a load
    function automatic acc_e norm_acc(input logic [1:0] code);
        acc_e a;
        a = acc_e'(code);
        return (a == ACC_RSVD) ? ACC_LOAD : a;
    endfunction

    function automatic logic needs_extra(input acc_e a, input logic carry);
        return carry || (a != ACC_LOAD);
    endfunction

endpackage

// File: rtl/idx_op_latch.sv
module idx_op_latch
    import idx_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  op_t  op_in,
    output op_t  op_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (load) begin
            op_q <= op_in;
        end
    end

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import idx_seq_pkg::*;
(
    input  op_t   op,
    output addr_t agen
);

    logic [IDX_W:0] lo_sum;

    always_comb begin
        lo_sum     = {1'b0, op.base[IDX_W-1:0]} + {1'b0, op.idx};
        agen.carry = lo_sum[IDX_W];
        agen.pfa   = {op.base[ADDR_W-1:IDX_W], lo_sum[IDX_W-1:0]};
    end

endmodule

// File: rtl/idx_cycle_fsm.sv
module idx_cycle_fsm
    import idx_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  acc_e acc,
    input  logic carry,
    output cyc_e state,
    output logic accept,
    output logic done
);

    cyc_e nxt;

    assign accept = start && (state == CY_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            CY_IDLE: begin
                if (accept) begin
                    nxt = needs_extra(acc, carry) ? CY_EXTRA : CY_READ;
                end
            end
            CY_EXTRA: nxt = (acc == ACC_STORE) ? CY_WRITE : CY_READ;
            CY_READ:  nxt = (acc == ACC_RMW) ? CY_DUMMY : CY_IDLE;
            CY_DUMMY: nxt = CY_WRITE;
            CY_WRITE: nxt = CY_IDLE;
            default:  nxt = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CY_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign done = (state == CY_WRITE) ||
                  ((state == CY_READ) && (acc != ACC_RMW));

    AST_DUMMY_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == CY_DUMMY) |=> (state == CY_WRITE)); // R8

    AST_EXTRA_THEN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (state == CY_EXTRA) |=> ((state == CY_READ) || (state == CY_WRITE))); // R3

endmodule

// File: rtl/idx_bus_mux.sv
module idx_bus_mux
    import idx_seq_pkg::*;
#(
    parameter bit PC_ON_CARRY = 1'b1
)(
    input  cyc_e              state,
    input  addr_t             agen,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr,
    output logic              rnw
);

    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(1) << IDX_W;

    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] extra_addr;

    assign ea = agen.pfa + (agen.carry ? HI_STEP : '0);

    generate
        if (PC_ON_CARRY) begin : g_pc_policy
            assign extra_addr = agen.carry ? pc : ea;
        end else begin : g_pfa_policy
            assign extra_addr = agen.pfa;
        end
    endgenerate

    always_comb begin
        unique case (state)
            CY_IDLE:  addr = '0;
            CY_EXTRA: addr = extra_addr;
            default:  addr = ea;
        endcase
        rnw = (state != CY_WRITE);
    end

endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
    import idx_seq_pkg::*;
#(
    parameter bit PC_ON_CARRY = 1'b1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] base_addr,
    input  logic [7:0]  index_val,
    input  logic [1:0]  access,
    input  logic [15:0] prog_ctr,
    output logic [15:0] bus_addr,
    output logic        bus_rnw,
    output logic [2:0]  cyc_kind,
    output logic        seq_done,
    output logic        seq_busy
);

    op_t   op_live;
    op_t   op_q;
    op_t   op_cur;
    addr_t agen;
    cyc_e  state;
    logic  accept;

    always_comb begin
        op_live.base = base_addr;
        op_live.idx  = index_val;
        op_live.acc  = norm_acc(access);
        op_live.pc   = prog_ctr;
    end

    // idle: decide from live operands; busy: from captured ones
    assign op_cur = (state == CY_IDLE) ? op_live : op_q;

    idx_op_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .op_in (op_live),
        .op_q  (op_q)
    );

    idx_addr_gen u_agen (
        .op   (op_cur),
        .agen (agen)
    );

    idx_cycle_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .acc    (op_cur.acc),
        .carry  (agen.carry),
        .state  (state),
        .accept (accept),
        .done   (seq_done)
    );

    idx_bus_mux #(.PC_ON_CARRY(PC_ON_CARRY)) u_mux (
        .state (state),
        .agen  (agen),
        .pc    (op_cur.pc),
        .addr  (bus_addr),
        .rnw   (bus_rnw)
    );

    assign cyc_kind = state;
    assign seq_busy = (state != CY_IDLE);

    AST_EXTRA_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (state == CY_EXTRA) |-> bus_rnw); // R6

    AST_OPS_HELD: assert property (@(posedge clk) disable iff (rst)
        ((state != CY_IDLE) && ($past(state) != CY_IDLE)) |-> $stable(op_q)); // R9

    AST_STORE_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        ((state == CY_WRITE) && ($past(state) == CY_EXTRA) && !$past(agen.carry))
        |-> (bus_addr == $past(bus_addr))); // R7

    AST_RMW_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == CY_DUMMY) |=> (bus_addr == $past(bus_addr))); // R8

    generate
        if (!PC_ON_CARRY) begin : g_pfa_check
            AST_PFA_STEP: assert property (@(posedge clk) disable iff (rst)
                (state == CY_EXTRA) |=>
                (bus_addr == $past(bus_addr) + ($past(agen.carry) ? 16'h0100 : 16'h0000))); // R4
        end
    endgenerate

endmodule

// File: tb/idx_bus_seq_test.sv
module idx_bus_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [7:0]  index_val = '0;
    logic [1:0]  access = '0;
    logic [15:0] prog_ctr = '0;

    logic [15:0] i_addr, l_addr;
    logic        i_rnw, l_rnw, i_done, l_done, i_busy, l_busy;
    logic [2:0]  i_kind, l_kind;

    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    idx_bus_seq #(.PC_ON_CARRY(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .index_val(index_val), .access(access), .prog_ctr(prog_ctr),
        .bus_addr(i_addr), .bus_rnw(i_rnw), .cyc_kind(i_kind),
        .seq_done(i_done), .seq_busy(i_busy)
    );

    idx_bus_seq #(.PC_ON_CARRY(1'b0)) uut_legacy (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .index_val(index_val), .access(access), .prog_ctr(prog_ctr),
        .bus_addr(l_addr), .bus_rnw(l_rnw), .cyc_kind(l_kind),
        .seq_done(l_done), .seq_busy(l_busy)
    );

    // expected trace, [policy][cycle]; policy 1 = PC on carry
    logic [15:0] x_addr [0:1][0:4];
    logic        x_rnw  [0:1][0:4];
    logic [2:0]  x_kind [0:1][0:4];
    string       x_tag  [0:1][0:4];
    int          x_n;

    task automatic build(input logic [15:0] b, input logic [7:0] ix,
                         input logic [1:0] ac, input logic [15:0] p);
        int sum_lo = int'(b[7:0]) + int'(ix);
        bit cy = (sum_lo > 255);
        logic [15:0] ea = b + {8'h00, ix};
        logic [15:0] pfa = {b[15:8], ea[7:0]};
        int a = (ac == 2'd3) ? 0 : int'(ac);
        string ftag = (cy && b[15:8] == 8'hFF) ? "R1" : ((ac == 2'd3) ? "R11" : "R10");
        for (int pol = 0; pol < 2; pol++) begin
            int k = 0;
            if (cy || a != 0) begin
                x_kind[pol][k] = 3'd1; x_rnw[pol][k] = 1'b1;
                if (pol == 0) begin
                    x_addr[pol][k] = pfa; x_tag[pol][k] = "R4";
                end else begin
                    x_addr[pol][k] = cy ? p : ea;
                    x_tag[pol][k] = cy ? "R5" : ((a == 1) ? "R7" : "R8");
                end
                k++;
            end
            if (a == 1) begin
                x_kind[pol][k] = 3'd4; x_rnw[pol][k] = 1'b0; x_addr[pol][k] = ea;
                x_tag[pol][k] = (ftag == "R10") ? "R6" : ftag; k++;
            end else if (a == 2) begin
                x_kind[pol][k] = 3'd2; x_rnw[pol][k] = 1'b1; x_addr[pol][k] = ea; x_tag[pol][k] = "R8"; k++;
                x_kind[pol][k] = 3'd3; x_rnw[pol][k] = 1'b1; x_addr[pol][k] = ea; x_tag[pol][k] = "R8"; k++;
                x_kind[pol][k] = 3'd4; x_rnw[pol][k] = 1'b0; x_addr[pol][k] = ea; x_tag[pol][k] = ftag; k++;
            end else begin
                x_kind[pol][k] = 3'd2; x_rnw[pol][k] = 1'b1; x_addr[pol][k] = ea;
                x_tag[pol][k] = (ftag != "R10") ? ftag : (cy ? "R3" : "R2"); k++;
            end
            x_n = k;
        end
    endtask

    task automatic chk(input string tag, input int pol, input int c,
                       input logic [15:0] a, input logic r, input logic [2:0] k, input logic d,
                       input logic [15:0] ea_, input logic er, input logic [2:0] ek, input logic ed);
        n_checks++;
        if (a !== ea_ || r !== er || k !== ek || d !== ed) begin
            n_err++;
            $display("FAIL %s pol=%0d cyc=%0d got addr=%h rnw=%b kind=%0d done=%b exp addr=%h rnw=%b kind=%0d done=%b",
                     tag, pol, c, a, r, k, d, ea_, er, ek, ed);
        end
    endtask

    task automatic run_one(input logic [15:0] b, input logic [7:0] ix,
                           input logic [1:0] ac, input logic [15:0] p, input bit noisy);
        build(b, ix, ac, p);
        @(negedge clk);
        base_addr = b; index_val = ix; access = ac; prog_ctr = p; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (noisy) begin
            // R9: restart attempt with different operands while busy
            base_addr = ~b; index_val = ~ix; access = ac ^ 2'd1; prog_ctr = ~p;
        end else begin
            start = 1'b0;
        end
        for (int c = 0; c < x_n; c++) begin
            chk(noisy ? "R9" : x_tag[1][c], 1, c, i_addr, i_rnw, i_kind, i_done,
                x_addr[1][c], x_rnw[1][c], x_kind[1][c], c == x_n - 1);
            chk(noisy ? "R9" : x_tag[0][c], 0, c, l_addr, l_rnw, l_kind, l_done,
                x_addr[0][c], x_rnw[0][c], x_kind[0][c], c == x_n - 1);
            if (c < x_n - 1) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R10: back to idle after the last bus cycle
        chk("R10", 1, x_n, i_addr, i_rnw, i_kind, i_done, 16'h0000, 1'b1, 3'd0, 1'b0);
        chk("R10", 0, x_n, l_addr, l_rnw, l_kind, l_done, 16'h0000, 1'b1, 3'd0, 1'b0);
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] lows [0:3];
        logic [7:0] highs [0:2];
        logic [7:0] idxs [0:3];
        lows = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        highs = '{8'h00, 8'h12, 8'hFF};
        idxs = '{8'h00, 8'h01, 8'h80, 8'hFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10", 1, 0, i_addr, i_rnw, i_kind, i_done, 16'h0000, 1'b1, 3'd0, 1'b0);
        chk("R10", 0, 0, l_addr, l_rnw, l_kind, l_done, 16'h0000, 1'b1, 3'd0, 1'b0);
        for (int h = 0; h < 3; h++)
            for (int l = 0; l < 4; l++)
                for (int x = 0; x < 4; x++)
                    for (int ac = 0; ac < 4; ac++) begin
                        logic [15:0] bb = {highs[h], lows[l]};
                        logic [15:0] pp = {4'hC, lows[l][3:0], idxs[x]} ^ {6'd0, 2'(ac), 8'd0};
                        run_one(bb, idxs[x], 2'(ac), pp, (x == 2) && (h != 0));
                    end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule